// File: doc/BRIEF.md
# Paged serial configuration memory reader

This block holds a configuration bitstream in a small byte array and shifts it out one bit per clock on a serial data line. An external programmable-logic device drives the clock, an active-low chip enable and a combined control input that resets the read position when low and enables the output when high. Bits leave each byte most-significant first, and bytes are read in ascending address order.

The array can be used as one region or split into four equal pages. A two-bit select picks the page, and the block captures that choice while the read position is held in reset. When the last bit of the region has been sent, the data driver turns off and the cascade enable output goes low, so the next device in a daisy chain can take over. After power-up, a ready flag stays low for a fixed number of cycles while the position is initialised. A serial-mode enable, when low, freezes reading and keeps the output undriven. A simple write port fills the array for test.

Top module: `cfg_stream_reader`

## Requirements
- R1: After rst_ni is released, ready_o stays 0 for POR_CYCLES rising edges (default 4) and is 1 from then on. While ready_o is 0, data_oe_o is 0 and ceo_no is 1.
- R2: With ser_en_i=1 and rst_oe_i=0, data_oe_o is 0 whatever ce_ni is. Each such clock edge returns the read position to the start of the region, and the region choice is taken from page_en_i and page_sel_i at that time.
- R3: With ready_o=1, ser_en_i=1, rst_oe_i=1, ce_ni=0 and the end not yet reached, data_oe_o is 1 and data_o is bit (7 - k mod 8) of byte (start + k div 8), where k counts the rising edges since the read started. Each such edge advances k by one.
- R4: With ce_ni=1, data_oe_o is 0 and the read position is held, so reading resumes at the same bit when ce_ni returns to 0.
- R5: With page_en_i=1 at reset time, the region is page page_sel_i, which starts at byte page_sel_i*DEPTH/4 and holds DEPTH/4 bytes, so exactly DEPTH*2 bits are sent.
- R6: With page_en_i=0 at reset time, the region is the whole array starting at byte 0, so exactly DEPTH*8 bits are sent.
- R7: Once the last bit of the region has been clocked out, data_oe_o stays 0 and ceo_no equals ce_ni (low while chip enable is low), until the next position reset.
- R8: A position reset (rst_oe_i=0 with ser_en_i=1) clears the end condition, so ceo_no is 1 until the region has been read through again.
- R9: With ser_en_i=0, data_oe_o is 0, ceo_no is 1, and ce_ni, rst_oe_i, page_en_i and page_sel_i do not change the read position. Reading resumes where it stopped when ser_en_i returns to 1.
- R10: Changes to page_en_i or page_sel_i while a read is under way do not change the region until the next position reset.
- R11: A cycle with wr_en_i=1 stores wr_data_i at byte wr_addr_i, and a later read returns that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| ser_en_i | input | 1 | Serial read mode enable (1 = reading allowed) |
| ce_ni | input | 1 | Active-low chip enable |
| rst_oe_i | input | 1 | 0 = reset read position, 1 = output enable |
| page_en_i | input | 1 | 1 = array split into four pages |
| page_sel_i | input | 2 | Page index used in page mode |
| wr_en_i | input | 1 | Test write strobe |
| wr_addr_i | input | $clog2(DEPTH) | Test write byte address |
| wr_data_i | input | 8 | Test write byte |
| data_o | output | 1 | Serial data value (0 when not driven) |
| data_oe_o | output | 1 | Data driver enable |
| ceo_no | output | 1 | Active-low cascade enable output |
| ready_o | output | 1 | Power-up complete flag |

## Verification
The bench uses the default DEPTH of 16 bytes and POR_CYCLES of 4. With these values a page is 32 bits long and the whole array is 128 bits, so random stimulus regularly reaches the end of every page and of the whole array between its frequent position resets. This exercises the cascade output, the end-of-region tri-state and the latching of the page choice many times over. The short power-up window keeps the start-up checks at the exact edge where the ready flag rises.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    RD_HOLD  = 2'd0,
    RD_CLEAR = 2'd1,
    RD_RUN   = 2'd2
  } rd_cmd_e;
endpackage

// File: rtl/cfg_por.sv
module cfg_por #(
  parameter int unsigned POR_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(POR_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (cnt_q != CW'(POR_CYCLES)) cnt_q <= cnt_q + 1'b1;
  end

  assign ready_o = (cnt_q == CW'(POR_CYCLES));

  a_r1_ready_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
endmodule

// File: rtl/cfg_mem.sv
module cfg_mem #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned BW = $clog2(BYTE_W)
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  input  logic [BW-1:0]     rd_bit_i,
  output logic              rd_data_o
);
  logic [BYTE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  // bit index 0 selects the MSB
  assign rd_data_o = mem_q[rd_addr_i][BW'(BYTE_W - 1) - rd_bit_i];
endmodule

// File: rtl/cfg_counter.sv
module cfg_counter
  import cfg_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned BW = $clog2(BYTE_W),
  localparam int unsigned PG = DEPTH / 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ready_i,
  input  logic          ser_en_i,
  input  logic          ce_ni,
  input  logic          rst_oe_i,
  input  logic          page_en_i,
  input  logic [1:0]    page_sel_i,
  output logic [AW-1:0] addr_o,
  output logic [BW-1:0] bit_o,
  output logic          done_o
);
  logic [AW-1:0] addr_q, base_q, base_w, top_w;
  logic [BW-1:0] bit_q;
  logic          done_q, pg_en_q;
  rd_cmd_e       cmd;

  always_comb begin
    base_w = page_en_i ? (AW'(page_sel_i) << (AW - 2)) : '0;
    top_w  = pg_en_q ? (base_q | AW'(PG - 1)) : AW'(DEPTH - 1);
  end

  always_comb begin
    if (!ready_i)                cmd = RD_CLEAR;
    else if (!ser_en_i)          cmd = RD_HOLD;
    else if (!rst_oe_i)          cmd = RD_CLEAR;
    else if (!ce_ni && !done_q)  cmd = RD_RUN;
    else                         cmd = RD_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      bit_q   <= '0;
      done_q  <= 1'b0;
      base_q  <= '0;
      pg_en_q <= 1'b0;
    end else begin
      unique case (cmd)
        RD_CLEAR: begin
          base_q  <= base_w;
          pg_en_q <= page_en_i;
          addr_q  <= base_w;
          bit_q   <= '0;
          done_q  <= 1'b0;
        end
        RD_RUN: begin
          if (bit_q == BW'(BYTE_W - 1)) begin
            bit_q <= '0;
            if (addr_q == top_w) done_q <= 1'b1;
            else                 addr_q <= addr_q + 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign addr_o = addr_q;
  assign bit_o  = bit_q;
  assign done_o = done_q;

  a_r3_bit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && ser_en_i && rst_oe_i && !ce_ni && !done_q && bit_q != BW'(BYTE_W - 1))
      |=> (bit_q == BW'($past(bit_q) + 1'b1)) && $stable(addr_q));

  a_r4_ce_high_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && ser_en_i && rst_oe_i && ce_ni)
      |=> $stable(addr_q) && $stable(bit_q) && $stable(done_q));

  a_r9_serial_off_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && !ser_en_i)
      |=> $stable(addr_q) && $stable(bit_q) && $stable(done_q) && $stable(base_q));

  a_r7_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && ready_i && (!ser_en_i || rst_oe_i)) |=> done_q);

  a_r10_region_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && ser_en_i && rst_oe_i) |=> $stable(base_q) && $stable(pg_en_q));
endmodule

// File: rtl/cfg_stream_reader.sv
module cfg_stream_reader
  import cfg_pkg::*;
#(
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned POR_CYCLES = 4,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned BW = $clog2(BYTE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_en_i,
  input  logic              ce_ni,
  input  logic              rst_oe_i,
  input  logic              page_en_i,
  input  logic [1:0]        page_sel_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic              data_o,
  output logic              data_oe_o,
  output logic              ceo_no,
  output logic              ready_o
);
  logic          ready;
  logic [AW-1:0] rd_addr;
  logic [BW-1:0] rd_bit;
  logic          done;
  logic          mem_bit;
  logic          active;

  cfg_por #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ready_o (ready)
  );

  cfg_counter #(.DEPTH(DEPTH)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ready_i    (ready),
    .ser_en_i   (ser_en_i),
    .ce_ni      (ce_ni),
    .rst_oe_i   (rst_oe_i),
    .page_en_i  (page_en_i),
    .page_sel_i (page_sel_i),
    .addr_o     (rd_addr),
    .bit_o      (rd_bit),
    .done_o     (done)
  );

  cfg_mem #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_mem (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr),
    .rd_bit_i  (rd_bit),
    .rd_data_o (mem_bit)
  );

  assign active    = ready && ser_en_i && rst_oe_i && !ce_ni;
  assign data_oe_o = active && !done;
  assign data_o    = data_oe_o ? mem_bit : 1'b0;
  assign ceo_no    = !(ready && ser_en_i && done && !ce_ni);
  assign ready_o   = ready;

  a_r1_quiet_before_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> !data_oe_o && ceo_no);

  a_r2_reset_tristate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_en_i && !rst_oe_i) |-> !data_oe_o);

  a_r8_reset_clears_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && ser_en_i && !rst_oe_i) |=> ceo_no);

  a_r7_no_drive_with_ceo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ceo_no |-> !data_oe_o);

  a_r9_serial_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_en_i |-> !data_oe_o && ceo_no);
endmodule

// File: tb/cfg_stream_reader_bench.sv
module cfg_stream_reader_bench;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned POR   = 4;
  localparam int unsigned AW    = $clog2(DEPTH);
  localparam int unsigned PG    = DEPTH / 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ser_en = 1'b1, ce_n = 1'b1, rst_oe = 1'b0, page_en = 1'b0;
  logic [1:0] page_sel = 2'd0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic data, data_oe, ceo_n, ready;

  int errors = 0;
  int checks = 0;
  int bits_seen = 0;
  bit first_bit_ok = 1'b1;

  // reference state
  logic [7:0] mem_m [DEPTH];
  int por_m = 0;
  int pos_m = 0;
  int base_m = 0;
  int len_m = DEPTH * 8;
  bit done_m = 1'b0;

  always #5 clk = ~clk;

  cfg_stream_reader #(.DEPTH(DEPTH), .POR_CYCLES(POR)) u_cfg_stream_reader (
    .clk_i(clk), .rst_ni(rst_ni), .ser_en_i(ser_en), .ce_ni(ce_n),
    .rst_oe_i(rst_oe), .page_en_i(page_en), .page_sel_i(page_sel),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .data_o(data), .data_oe_o(data_oe), .ceo_no(ceo_n), .ready_o(ready)
  );

  function automatic int region_base(bit pe, logic [1:0] sel);
    return pe ? int'(sel) * PG : 0;
  endfunction

  function automatic int region_len(bit pe);
    return pe ? PG * 8 : DEPTH * 8;
  endfunction

  function automatic bit exp_ready();
    return por_m == POR;
  endfunction

  function automatic bit exp_oe();
    return exp_ready() && ser_en && rst_oe && !ce_n && !done_m;
  endfunction

  function automatic bit exp_bit();
    logic [7:0] b;
    b = mem_m[base_m + pos_m / 8];
    return b[7 - (pos_m % 8)];
  endfunction

  function automatic bit exp_ceo_n();
    return !(exp_ready() && ser_en && done_m && !ce_n);
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      por_m = 0; pos_m = 0; done_m = 1'b0; base_m = 0; len_m = DEPTH * 8;
    end else begin
      if (wr_en) mem_m[wr_addr] = wr_data;
      if (por_m < POR) begin
        por_m++;
        base_m = region_base(page_en, page_sel); len_m = region_len(page_en);
        pos_m = 0; done_m = 1'b0;
      end else if (!ser_en) begin
      end else if (!rst_oe) begin
        base_m = region_base(page_en, page_sel); len_m = region_len(page_en);
        pos_m = 0; done_m = 1'b0;
      end else if (!ce_n && !done_m) begin
        if (pos_m == len_m - 1) done_m = 1'b1;
        else pos_m++;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare all outputs against the reference, then move to the next cycle
  task automatic tick(string tag);
    #1;
    check({tag, " ready"}, int'(ready), int'(exp_ready()));
    check({tag, " oe"}, int'(data_oe), int'(exp_oe()));
    check({tag, " ceo"}, int'(ceo_n), int'(exp_ceo_n()));
    if (exp_oe()) begin
      check({tag, " R3 data"}, int'(data), int'(exp_bit()));
      if (pos_m == 0 && data != exp_bit()) first_bit_ok = 1'b0;
      bits_seen++;
    end
    @(negedge clk);
  endtask

  task automatic pos_reset(bit pe, logic [1:0] sel);
    page_en = pe; page_sel = sel; rst_oe = 1'b0; ce_n = 1'b1;
    tick("R2");
    rst_oe = 1'b1;
  endtask

  initial begin : watchdog
    #1500000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [1:0] held_sel;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < DEPTH; i++) mem_m[i] = 8'h00;
    #2;
    // R1 reset state
    check("R1 reset ready", int'(ready), 0);
    check("R1 reset oe", int'(data_oe), 0);
    check("R1 reset ceo", int'(ceo_n), 1);
    @(negedge clk);
    rst_ni = 1'b1;
    rst_oe = 1'b1; ce_n = 1'b0;
    for (int i = 0; i < POR; i++) begin
      check("R1 still not ready", int'(ready), 0);
      tick("R1");
    end
    #1 check("R1 ready after window", int'(ready), 1);

    // R11 fill array through the write port
    ce_n = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      wr_en = 1'b1; wr_addr = AW'(i); wr_data = 8'($urandom);
      tick("R11");
    end
    wr_en = 1'b0;

    // R6 whole-array read, R7 end behaviour
    pos_reset(1'b0, 2'd0);
    ce_n = 1'b0; bits_seen = 0; first_bit_ok = 1'b1;
    for (int i = 0; i < DEPTH * 8 + 4; i++) tick("R6");
    check("R6 bits in full read", bits_seen, DEPTH * 8);
    check("R11 first bit of stored byte", int'(first_bit_ok), 1);
    #1 check("R7 ceo low at end", int'(ceo_n), 0);
    check("R7 data off at end", int'(data_oe), 0);
    ce_n = 1'b1;
    #1 check("R7 ceo follows ce", int'(ceo_n), 1);
    tick("R7");
    ce_n = 1'b0;
    #1 check("R7 ceo low again", int'(ceo_n), 0);
    tick("R7");
    rst_oe = 1'b0;
    tick("R8");
    rst_oe = 1'b1;
    #1 check("R8 ceo released", int'(ceo_n), 1);

    // R4 pause with ce high, R9 pause with serial mode off
    bits_seen = 0;
    for (int i = 0; i < 20; i++) tick("R3");
    ce_n = 1'b1;
    for (int i = 0; i < 5; i++) tick("R4");
    ce_n = 1'b0;
    for (int i = 0; i < 20; i++) tick("R4");
    ser_en = 1'b0; rst_oe = 1'b0; page_en = 1'b1; page_sel = 2'd3;
    for (int i = 0; i < 5; i++) tick("R9");
    ser_en = 1'b1; rst_oe = 1'b1;
    for (int i = 0; i < DEPTH * 8; i++) tick("R9");
    check("R9 bits with pauses", bits_seen, DEPTH * 8);

    // R5 each page, R10 select changes mid-read
    for (int p = 0; p < 4; p++) begin
      pos_reset(1'b1, 2'(p));
      ce_n = 1'b0; bits_seen = 0; first_bit_ok = 1'b1;
      held_sel = 2'(p);
      for (int i = 0; i < PG * 8 + 3; i++) begin
        if (i == 9) begin page_sel = ~held_sel; page_en = 1'b0; end
        tick("R10");
      end
      check("R5 bits in page", bits_seen, PG * 8);
      check("R5 page start bit", int'(first_bit_ok), 1);
      #1 check("R5 ceo at page end", int'(ceo_n), 0);
    end

    // random phase
    for (int i = 0; i < 6000; i++) begin
      ser_en = ($urandom % 16) != 0;
      ce_n   = ($urandom % 8) == 0;
      rst_oe = ($urandom % 48) != 0;
      if ($urandom % 16 == 0) page_en = 1'($urandom);
      if ($urandom % 8 == 0) page_sel = 2'($urandom);
      wr_en = ($urandom % 32) == 0;
      wr_addr = AW'($urandom);
      wr_data = 8'($urandom);
      tick("R3 random");
    end
    wr_en = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule